// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block keeps the program-counter state of a fetch unit whose architecture has one branch delay slot and whose macro-instructions may expand into several micro-ops. It holds three byte addresses (the instruction being fetched, the one after it, and the one after that) and a pair of micro-op counters (the current micro-op index and the index that follows it). Instructions have a fixed size in bytes, set by a parameter.

A controlling pipeline drives one command per cycle: load a fresh address, step to the next instruction, install a taken-branch target as the third address so that it lands behind the delay slot, step one micro-op inside a macro-instruction, or finish a macro-instruction. All state is presented on registered outputs. A combinational flag, derived from the registered state, tells the pipeline whether the flow it holds is anything other than plain sequential execution.

Top module: `pcseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, all five state outputs become zero; in that state `flow_break` is 1.
- R2: A load command with address A gives `cur_pc`=A, `nxt_pc`=A+S, `nxt2_pc`=A+2S, `cur_upc`=0 and `nxt_upc`=1 after the edge, where S is the instruction size in bytes.
- R3: An advance command moves `nxt_pc` into `cur_pc` and `nxt2_pc` into `nxt_pc`, and adds S to `nxt2_pc`; the micro-op counters are left as they were.
- R4: A set-target command writes `target_addr` into `nxt2_pc` and leaves every other state output unchanged.
- R5: A micro-advance command copies `nxt_upc` into `cur_upc` and sets `nxt_upc` to its old value plus one; the three byte addresses stay unchanged.
- R6: An end-of-macro-op command performs the same address shift as advance and sets `cur_upc` to 0 and `nxt_upc` to 1.
- R7: When several commands are high together, only one acts, chosen in the order load, end-of-macro-op, advance, micro-advance, set-target (highest first).
- R8: The address part counts as sequential only when `nxt2_pc` equals `nxt_pc`+S and `nxt_pc` equals either `cur_pc`+S or `cur_pc`+2S; otherwise `flow_break` is 1, in the same cycle the state shows it.
- R9: `flow_break` is also 1 whenever `nxt_upc` differs from `cur_upc`+1.
- R10: With no command high, all state outputs hold their values.
- R11: All address and micro-op arithmetic wraps modulo 2 to the power of its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| do_load | input | 1 | Load `load_addr` as a new fetch address |
| do_end | input | 1 | Finish the current macro-instruction |
| do_adv | input | 1 | Step to the next instruction |
| do_uadv | input | 1 | Step to the next micro-op |
| do_settgt | input | 1 | Install `target_addr` as the third address |
| load_addr | input | AW | Address used by the load command |
| target_addr | input | AW | Branch target used by the set-target command |
| cur_pc | output | AW | Address of the current instruction |
| nxt_pc | output | AW | Address of the next instruction |
| nxt2_pc | output | AW | Address of the instruction after next |
| cur_upc | output | UW | Current micro-op index |
| nxt_upc | output | UW | Next micro-op index |
| flow_break | output | 1 | Non-sequential flow indicator |

## Verification
On every cycle the assertions check the effect of each winning command on the next state (load values, the address shift with the S increment, the micro-op step, the target write, the reset of the micro counters at macro end) and that an idle cycle holds everything. The flag's exact sequential rule, in particular acceptance of a two-instruction gap and rejection of a three-instruction gap, the command priority under overlapping requests, and address wrap at the top of the space are shown only by the bench's directed scenarios, which compare every output against a reference computed from the requirements.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_END   = 3'd2,
    OP_ADV   = 3'd3,
    OP_UADV  = 3'd4,
    OP_SETTG = 3'd5
  } seq_op_e;
endpackage

// File: rtl/pcseq_cmd_arb.sv
module pcseq_cmd_arb
  import pcseq_pkg::*;
(
  input  logic    do_load,
  input  logic    do_end,
  input  logic    do_adv,
  input  logic    do_uadv,
  input  logic    do_settgt,
  output seq_op_e op
);
  always_comb begin
    if (do_load)        op = OP_LOAD;
    else if (do_end)    op = OP_END;
    else if (do_adv)    op = OP_ADV;
    else if (do_uadv)   op = OP_UADV;
    else if (do_settgt) op = OP_SETTG;
    else                op = OP_IDLE;
  end
endmodule

// File: rtl/pcseq_addr_pipe.sv
module pcseq_addr_pipe
  import pcseq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int ISZ = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_op_e       op,
  input  logic [AW-1:0] load_addr,
  input  logic [AW-1:0] target_addr,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] npc_q,
  output logic [AW-1:0] nnpc_q
);
  localparam logic [AW-1:0] STEP  = AW'(ISZ);
  localparam logic [AW-1:0] STEP2 = AW'(2 * ISZ);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      npc_q  <= '0;
      nnpc_q <= '0;
    end else begin
      unique case (op)
        OP_LOAD: begin
          pc_q   <= load_addr;
          npc_q  <= load_addr + STEP;
          nnpc_q <= load_addr + STEP2;
        end
        OP_END, OP_ADV: begin
          pc_q   <= npc_q;
          npc_q  <= nnpc_q;
          nnpc_q <= nnpc_q + STEP;
        end
        OP_SETTG: nnpc_q <= target_addr;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pcseq_micro.sv
module pcseq_micro
  import pcseq_pkg::*;
#(
  parameter int UW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_op_e       op,
  output logic [UW-1:0] upc_q,
  output logic [UW-1:0] nupc_q
);
  localparam logic [UW-1:0] ONE = UW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      upc_q  <= '0;
      nupc_q <= '0;
    end else begin
      unique case (op)
        OP_LOAD, OP_END: begin
          upc_q  <= '0;
          nupc_q <= ONE;
        end
        OP_UADV: begin
          upc_q  <= nupc_q;
          nupc_q <= nupc_q + ONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pcseq_flow.sv
module pcseq_flow #(
  parameter int AW  = 32,
  parameter int UW  = 16,
  parameter int ISZ = 4
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] npc,
  input  logic [AW-1:0] nnpc,
  input  logic [UW-1:0] upc,
  input  logic [UW-1:0] nupc,
  output logic          brk
);
  localparam logic [AW-1:0] STEP  = AW'(ISZ);
  localparam logic [AW-1:0] STEP2 = AW'(2 * ISZ);

  logic tail_ok, head_ok, micro_ok;

  always_comb begin
    tail_ok  = (nnpc == npc + STEP);
    head_ok  = (npc == pc + STEP) || (npc == pc + STEP2);
    micro_ok = (nupc == upc + UW'(1));
    brk      = !(tail_ok && head_ok) || !micro_ok;
  end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int UW  = 16,
  parameter int ISZ = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_load,
  input  logic          do_end,
  input  logic          do_adv,
  input  logic          do_uadv,
  input  logic          do_settgt,
  input  logic [AW-1:0] load_addr,
  input  logic [AW-1:0] target_addr,
  output logic [AW-1:0] cur_pc,
  output logic [AW-1:0] nxt_pc,
  output logic [AW-1:0] nxt2_pc,
  output logic [UW-1:0] cur_upc,
  output logic [UW-1:0] nxt_upc,
  output logic          flow_break
);
  seq_op_e op;

  pcseq_cmd_arb u_arb (
    .do_load   (do_load),
    .do_end    (do_end),
    .do_adv    (do_adv),
    .do_uadv   (do_uadv),
    .do_settgt (do_settgt),
    .op        (op)
  );

  pcseq_addr_pipe #(.AW(AW), .ISZ(ISZ)) u_addr (
    .clk         (clk),
    .rst         (rst),
    .op          (op),
    .load_addr   (load_addr),
    .target_addr (target_addr),
    .pc_q        (cur_pc),
    .npc_q       (nxt_pc),
    .nnpc_q      (nxt2_pc)
  );

  pcseq_micro #(.UW(UW)) u_micro (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .upc_q  (cur_upc),
    .nupc_q (nxt_upc)
  );

  pcseq_flow #(.AW(AW), .UW(UW), .ISZ(ISZ)) u_flow (
    .pc   (cur_pc),
    .npc  (nxt_pc),
    .nnpc (nxt2_pc),
    .upc  (cur_upc),
    .nupc (nxt_upc),
    .brk  (flow_break)
  );
endmodule

// File: rtl/pcseq_sva.sv
module pcseq_sva #(
  parameter int AW  = 32,
  parameter int UW  = 16,
  parameter int ISZ = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          do_load,
  input logic          do_end,
  input logic          do_adv,
  input logic          do_uadv,
  input logic          do_settgt,
  input logic [AW-1:0] load_addr,
  input logic [AW-1:0] target_addr,
  input logic [AW-1:0] cur_pc,
  input logic [AW-1:0] nxt_pc,
  input logic [AW-1:0] nxt2_pc,
  input logic [UW-1:0] cur_upc,
  input logic [UW-1:0] nxt_upc,
  input logic          flow_break
);
  localparam logic [AW-1:0] S1 = AW'(ISZ);
  localparam logic [AW-1:0] S2 = AW'(2 * ISZ);

  logic any_cmd;
  assign any_cmd = do_load | do_end | do_adv | do_uadv | do_settgt;

  // R2
  load_values_chk: assert property (@(posedge clk) disable iff (rst)
    do_load |=> cur_pc == $past(load_addr) && nxt_pc == $past(load_addr) + S1 &&
                nxt2_pc == $past(load_addr) + S2 && cur_upc == '0 && nxt_upc == UW'(1));

  // R8
  load_seq_chk: assert property (@(posedge clk) disable iff (rst)
    do_load |=> !flow_break);

  // R3
  adv_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (do_adv && !do_load && !do_end) |=> cur_pc == $past(nxt_pc) &&
      nxt_pc == $past(nxt2_pc) && nxt2_pc == $past(nxt2_pc) + S1 &&
      $stable(cur_upc) && $stable(nxt_upc));

  // R6
  end_macro_chk: assert property (@(posedge clk) disable iff (rst)
    (do_end && !do_load) |=> cur_pc == $past(nxt_pc) && nxt_pc == $past(nxt2_pc) &&
      nxt2_pc == $past(nxt2_pc) + S1 && cur_upc == '0 && nxt_upc == UW'(1));

  // R5
  uadv_step_chk: assert property (@(posedge clk) disable iff (rst)
    (do_uadv && !do_load && !do_end && !do_adv) |=> cur_upc == $past(nxt_upc) &&
      nxt_upc == $past(nxt_upc) + UW'(1) && $stable(cur_pc) && $stable(nxt_pc) &&
      $stable(nxt2_pc));

  // R4
  settgt_write_chk: assert property (@(posedge clk) disable iff (rst)
    (do_settgt && !do_load && !do_end && !do_adv && !do_uadv) |=>
      nxt2_pc == $past(target_addr) && $stable(cur_pc) && $stable(nxt_pc) &&
      $stable(cur_upc) && $stable(nxt_upc));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !any_cmd |=> $stable(cur_pc) && $stable(nxt_pc) && $stable(nxt2_pc) &&
      $stable(cur_upc) && $stable(nxt_upc));

  // R9
  micro_break_chk: assert property (@(posedge clk) disable iff (rst)
    (nxt_upc != cur_upc + UW'(1)) |-> flow_break);
endmodule

bind pcseq_top pcseq_sva #(.AW(AW), .UW(UW), .ISZ(ISZ)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .do_load     (do_load),
  .do_end      (do_end),
  .do_adv      (do_adv),
  .do_uadv     (do_uadv),
  .do_settgt   (do_settgt),
  .load_addr   (load_addr),
  .target_addr (target_addr),
  .cur_pc      (cur_pc),
  .nxt_pc      (nxt_pc),
  .nxt2_pc     (nxt2_pc),
  .cur_upc     (cur_upc),
  .nxt_upc     (nxt_upc),
  .flow_break  (flow_break)
);

// File: tb/tb_pcseq_top.sv
module tb_pcseq_top;
  localparam int AW  = 32;
  localparam int UW  = 16;
  localparam int ISZ = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic do_load = 0, do_end = 0, do_adv = 0, do_uadv = 0, do_settgt = 0;
  logic [AW-1:0] load_addr = '0, target_addr = '0;
  logic [AW-1:0] cur_pc, nxt_pc, nxt2_pc;
  logic [UW-1:0] cur_upc, nxt_upc;
  logic flow_break;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [AW-1:0] m_pc, m_npc, m_nnpc;
  logic [UW-1:0] m_upc, m_nupc;

  always #4 clk = ~clk;

  pcseq_top #(.AW(AW), .UW(UW), .ISZ(ISZ)) dut (
    .clk(clk), .rst(rst), .do_load(do_load), .do_end(do_end), .do_adv(do_adv),
    .do_uadv(do_uadv), .do_settgt(do_settgt), .load_addr(load_addr),
    .target_addr(target_addr), .cur_pc(cur_pc), .nxt_pc(nxt_pc), .nxt2_pc(nxt2_pc),
    .cur_upc(cur_upc), .nxt_upc(nxt_upc), .flow_break(flow_break)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_break();
    logic seq;
    seq = (m_nnpc == m_npc + AW'(ISZ)) &&
          ((m_npc == m_pc + AW'(ISZ)) || (m_npc == m_pc + AW'(2 * ISZ)));
    return !seq || (m_nupc != m_upc + UW'(1));
  endfunction

  task automatic chk_all(input string tag);
    chk({tag, " pc"},   64'(cur_pc),  64'(m_pc));
    chk({tag, " npc"},  64'(nxt_pc),  64'(m_npc));
    chk({tag, " nnpc"}, 64'(nxt2_pc), 64'(m_nnpc));
    chk({tag, " upc"},  64'(cur_upc), 64'(m_upc));
    chk({tag, " nupc"}, 64'(nxt_upc), 64'(m_nupc));
    chk({tag, " brk"},  64'(flow_break), 64'(exp_break()));
  endtask

  // apply one command cycle; the reference follows the priority of R7
  task automatic step(input logic l, input logic e, input logic a, input logic u,
                      input logic t, input logic [AW-1:0] la, input logic [AW-1:0] ta);
    @(negedge clk);
    do_load = l; do_end = e; do_adv = a; do_uadv = u; do_settgt = t;
    load_addr = la; target_addr = ta;
    if (l) begin
      m_pc = la; m_npc = la + AW'(ISZ); m_nnpc = la + AW'(2 * ISZ);
      m_upc = '0; m_nupc = UW'(1);
    end else if (e || a) begin
      m_pc = m_npc; m_npc = m_nnpc; m_nnpc = m_nnpc + AW'(ISZ);
      if (e) begin m_upc = '0; m_nupc = UW'(1); end
    end else if (u) begin
      m_upc = m_nupc; m_nupc = m_nupc + UW'(1);
    end else if (t) begin
      m_nnpc = ta;
    end
    @(negedge clk);
    do_load = 0; do_end = 0; do_adv = 0; do_uadv = 0; do_settgt = 0;
  endtask

  task automatic t_reset();
    m_pc = '0; m_npc = '0; m_nnpc = '0; m_upc = '0; m_nupc = '0;
    chk_all("R1 reset");
    chk("R1 R9 reset brk", 64'(flow_break), 64'd1);
  endtask

  task automatic t_load_adv();
    step(1,0,0,0,0, 32'h1000, 0);
    chk_all("R2 load");
    chk("R2 npc", 64'(nxt_pc), 64'h1004);
    step(0,0,1,0,0, 0, 0);
    chk_all("R3 adv1");
    chk("R3 nnpc", 64'(nxt2_pc), 64'h100C);
    step(0,0,1,0,0, 0, 0);
    chk_all("R3 adv2");
  endtask

  task automatic t_branch();
    step(1,0,0,0,0, 32'h4000, 0);
    step(0,0,0,0,1, 0, 32'h8000);
    chk_all("R4 settgt");
    chk("R8 target brk", 64'(flow_break), 64'd1);
    step(0,0,1,0,0, 0, 0);
    chk_all("R8 delay slot");
    step(0,0,1,0,0, 0, 0);
    chk_all("R8 at target");
    chk("R8 target pc", 64'(cur_pc), 64'h8000);
  endtask

  task automatic t_gaps();
    step(1,0,0,0,0, 32'h200, 0);
    step(0,0,0,0,1, 0, 32'h200 + 3 * ISZ);
    step(0,0,1,0,0, 0, 0);
    chk_all("R8 gap2");
    chk("R8 gap2 seq", 64'(flow_break), 64'd0);
    step(1,0,0,0,0, 32'h200, 0);
    step(0,0,0,0,1, 0, 32'h200 + 4 * ISZ);
    step(0,0,1,0,0, 0, 0);
    chk_all("R8 gap3");
    chk("R8 gap3 brk", 64'(flow_break), 64'd1);
  endtask

  task automatic t_micro();
    step(1,0,0,0,0, 32'h3000, 0);
    step(0,0,0,1,0, 0, 0);
    chk_all("R5 uadv1");
    step(0,0,0,1,0, 0, 0);
    chk_all("R5 uadv2");
    chk("R5 upc", 64'(cur_upc), 64'd2);
    step(0,1,0,0,0, 0, 0);
    chk_all("R6 end");
    chk("R6 pc", 64'(cur_pc), 64'h3004);
  endtask

  task automatic t_priority();
    step(0,0,0,1,0, 0, 0);
    step(1,1,1,1,1, 32'h5000, 32'h9999);
    chk_all("R7 load wins");
    step(0,0,0,1,0, 0, 0);
    step(0,1,1,1,1, 0, 32'h9999);
    chk_all("R7 end wins");
    step(0,0,1,1,1, 0, 32'h9999);
    chk_all("R7 adv wins");
    step(0,0,0,1,1, 0, 32'h9999);
    chk_all("R7 uadv wins");
    chk("R7 nnpc kept", 64'(nxt2_pc), 64'(m_nnpc));
  endtask

  task automatic t_idle();
    step(0,0,0,0,0, 32'h7777, 32'h7777);
    step(0,0,0,0,0, 32'h1111, 32'h2222);
    chk_all("R10 idle");
  endtask

  task automatic t_wrap();
    step(1,0,0,0,0, 32'hFFFF_FFFC, 0);
    chk_all("R11 wrap load");
    chk("R11 npc", 64'(nxt_pc), 64'h0);
    step(0,0,1,0,0, 0, 0);
    chk_all("R11 wrap adv");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_load_adv();
    t_branch();
    t_gaps();
    t_micro();
    t_priority();
    t_idle();
    t_wrap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule